// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a nine-tap FIR filter that forms the inner product of fixed coefficients and the nine most recent samples without any multiplier. Each accepted sample goes into a nine-deep history. The block then spends one clock per sample bit on the result. In each of those clocks it takes the bit of one weight from every stored sample, joins those nine bits into an address, and reads a precomputed table. Each table word is the sum of the coefficients whose address bit is set. A scaling accumulator adds every table word at the weight of its bit position. It subtracts the word that belongs to the sign bit, so the result stays correct for two's-complement samples.

Two coefficient banks are built at elaboration: a low-pass set and a high-pass set. A select input chooses the bank for each computation. The caller presents a sample together with a start strobe, waits until busy drops, and reads the signed result while the done strobe is high. The result stays on the output until the next done pulse.

Top module: `dafir_filter`

## Requirements
- R1: When done is high, result equals the sum over taps i = 0..8 of c[i]·x[i]. Here x[0] is the newest accepted sample, x[i] is the sample accepted i starts earlier, and samples and coefficients are signed two's-complement.
- R2: A bank select of 0 gives c = {2, 6, 15, 25, 30, 25, 15, 6, 2}. A bank select of 1 gives c = {-2, -6, -15, -25, 100, -25, -15, -6, -2}. Both are listed for tap 0 to tap 8.
- R3: A start seen at a clock edge while busy is low accepts sample_i into tap 0 and moves every older sample down one tap. Busy is high from the next cycle on.
- R4: A start seen while busy is high changes neither the sample history nor the result of the computation in progress.
- R5: After an accepted start, busy stays high for exactly SAMPLE_W (default 8) consecutive cycles.
- R6: Done is high for exactly one cycle, the first cycle after busy falls, and is never high while busy is high.
- R7: The result output changes only in a cycle where done is high, and otherwise holds its last value.
- R8: The bank select is sampled only with an accepted start. Changing it during a computation does not affect that computation.
- R9: After reset, busy and done are low, the result is 0, and all nine history taps hold 0.
- R10: The result is exact for the most negative sample value (-128 at the default width), including a full history of that value in either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Strobe: accept sample_i and begin a computation |
| sample_i | input | SAMPLE_W | Signed input sample |
| bank_sel_i | input | 1 | Coefficient bank: 0 low-pass, 1 high-pass |
| busy_o | output | 1 | High while the bit-serial computation runs |
| done_o | output | 1 | One-cycle strobe, result is new |
| result_o | output | SAMPLE_W+COEF_W+4 | Signed filter output |

## Verification
The filter is driven with an impulse into a zeroed history and with all-minimum and all-maximum histories. It is also driven with alternating extreme values and with seeded random samples, in both banks. The impulse shows the coefficients one tap at a time and confirms that the history starts cleared. The extreme histories reach the largest table words and the sign-bit subtraction. Random samples mix every address pattern, and comparing them against a multiply-accumulate model in the bench catches wrong tap order and wrong bit weighting. Some computations receive a second start and a flipped bank select while busy, which shows whether the block ignores them.

// File: rtl/dafir_pkg.sv
// Package: shared defaults, controller state type and the coefficient
// functions used to build the lookup tables at elaboration time.
// Assumes at most 9 taps carry non-zero coefficients.
package dafir_pkg;

    localparam int TAPS_DEF     = 9;
    localparam int SAMPLE_W_DEF = 8;
    localparam int COEF_W_DEF   = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_t;

    // Coefficient of tap idx in the chosen bank (hp = 1: high-pass).
    function automatic int coef(input bit hp, input int idx);
        int c;
        case (idx)
            0, 8:    c = 2;
            1, 7:    c = 6;
            2, 6:    c = 15;
            3, 5:    c = 25;
            4:       c = 30;
            default: c = 0;
        endcase
        if (hp) begin
            c = (idx == 4) ? 100 : -c;
        end
        return c;
    endfunction

    // Sum of the coefficients whose bit is set in addr.
    function automatic int lut_word(input bit hp, input int addr, input int taps);
        int s;
        s = 0;
        for (int i = 0; i < taps; i++) begin
            if (addr[i]) s += coef(hp, i);
        end
        return s;
    endfunction

endpackage

// File: rtl/dafir_history.sv
// Sample history: TAPS signed registers, tap 0 newest. Shifts only when
// shift_i is high. Gathers bit bit_idx_i of each tap into the table
// address, with tap i on address bit i.
module dafir_history #(
    parameter int TAPS     = 9,
    parameter int SAMPLE_W = 8,
    localparam int IW      = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [IW-1:0]       bit_idx_i,
    output logic [TAPS-1:0]     addr_o
);

    logic [SAMPLE_W-1:0] tap_q [TAPS];

    // Tap 0 register: load the new sample on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q[0] <= '0;
        end else if (shift_i) begin
            tap_q[0] <= sample_i;
        end
    end

    for (genvar t = 1; t < TAPS; t++) begin : g_tap
        // Older taps: take the neighbour's value on an accepted start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap_q[t] <= '0;
            end else if (shift_i) begin
                tap_q[t] <= tap_q[t-1];
            end
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_addr
        assign addr_o[t] = tap_q[t][bit_idx_i];
    end

endmodule

// File: rtl/dafir_lut.sv
// Coefficient-subset tables, one per bank, each 2^TAPS words filled at
// elaboration. Assumes TW is wide enough for any subset sum.
module dafir_lut #(
    parameter int TAPS = 9,
    parameter int TW   = 12,
    localparam int DEPTH = 1 << TAPS
) (
    input  logic                 bank_i,
    input  logic [TAPS-1:0]      addr_i,
    output logic signed [TW-1:0] word_o
);

    logic signed [TW-1:0] lp_rom [DEPTH];
    logic signed [TW-1:0] hp_rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        assign lp_rom[a] = TW'(dafir_pkg::lut_word(1'b0, a, TAPS));
        assign hp_rom[a] = TW'(dafir_pkg::lut_word(1'b1, a, TAPS));
    end

    // Bank-selected read.
    always_comb begin
        word_o = bank_i ? hp_rom[addr_i] : lp_rom[addr_i];
    end

endmodule

// File: rtl/dafir_accum.sv
// Scaling accumulator. Adds each table word shifted left by its bit
// index, and subtracts the word for the sign bit (last_i). Registers the
// finished sum as the result. Assumes RW >= TW + SAMPLE_W - 1.
module dafir_accum #(
    parameter int SAMPLE_W = 8,
    parameter int TW       = 12,
    parameter int RW       = 20,
    localparam int IW      = $clog2(SAMPLE_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 step_i,
    input  logic                 last_i,
    input  logic [IW-1:0]        bit_idx_i,
    input  logic signed [TW-1:0] word_i,
    output logic signed [RW-1:0] result_o
);

    logic signed [RW-1:0] acc_q;
    logic signed [RW-1:0] word_ext;
    logic signed [RW-1:0] weighted;
    logic signed [RW-1:0] sum_next;

    // Sign-extend, weight by bit position, add or subtract on the sign bit.
    always_comb begin
        word_ext = {{(RW-TW){word_i[TW-1]}}, word_i};
        weighted = word_ext <<< bit_idx_i;
        sum_next = last_i ? (acc_q - weighted) : (acc_q + weighted);
    end

    // Running sum: cleared on start, updated once per bit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= sum_next;
        end
    end

    // Output register: loaded only when the sign-bit step completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else if (step_i && last_i) begin
            result_o <= sum_next;
        end
    end

endmodule

// File: rtl/dafir_filter.sv
// Top: bit-serial lookup-table FIR. A start seen while idle loads the
// sample and latches the bank. SAMPLE_W cycles follow, one per bit, LSB
// first, and done then pulses with the result. Starts seen while busy
// are dropped. Assumes SAMPLE_W is a power of two, 2 or larger.
module dafir_filter #(
    parameter int TAPS     = dafir_pkg::TAPS_DEF,
    parameter int SAMPLE_W = dafir_pkg::SAMPLE_W_DEF,
    parameter int COEF_W   = dafir_pkg::COEF_W_DEF,
    localparam int TW      = COEF_W + $clog2(TAPS),
    localparam int RW      = SAMPLE_W + TW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                bank_sel_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [RW-1:0]       result_o
);

    localparam int IW = $clog2(SAMPLE_W);

    dafir_pkg::ctrl_state_t state_q;
    logic [IW-1:0]          bit_q;
    logic                   bank_q;
    logic                   done_q;
    logic                   accept;
    logic                   run;
    logic                   last;
    logic [TAPS-1:0]        addr;
    logic signed [TW-1:0]   word;
    logic signed [RW-1:0]   res;

    assign run    = (state_q == dafir_pkg::ST_RUN);
    assign accept = !run && start_i;
    assign last   = run && (bit_q == IW'(SAMPLE_W - 1));

    // Controller: idle/run sequencing, bit counter, bank latch, done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= dafir_pkg::ST_IDLE;
            bit_q   <= '0;
            bank_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (accept) begin
                state_q <= dafir_pkg::ST_RUN;
                bit_q   <= '0;
                bank_q  <= bank_sel_i;
            end else if (run) begin
                bit_q <= bit_q + 1'b1;
                if (last) state_q <= dafir_pkg::ST_IDLE;
            end
        end
    end

    dafir_history #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W)) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (accept),
        .sample_i  (sample_i),
        .bit_idx_i (bit_q),
        .addr_o    (addr)
    );

    dafir_lut #(.TAPS(TAPS), .TW(TW)) lut_i (
        .bank_i (bank_q),
        .addr_i (addr),
        .word_o (word)
    );

    dafir_accum #(.SAMPLE_W(SAMPLE_W), .TW(TW), .RW(RW)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .step_i    (run),
        .last_i    (last),
        .bit_idx_i (bit_q),
        .word_i    (word),
        .result_o  (res)
    );

    assign busy_o   = run;
    assign done_o   = done_q;
    assign result_o = res;

endmodule

// File: rtl/dafir_filter_chk.sv
// Checker for the port-level handshake of dafir_filter, bound into it.
// Counts busy cycles itself so the window length is not a $past depth.
module dafir_filter_chk #(
    parameter int SAMPLE_W = 8,
    parameter int RW       = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [RW-1:0] result_o
);

    int unsigned busy_run;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) busy_run <= 0;
        else                   busy_run <= busy_run + 1;
    end

    a_r3_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run == SAMPLE_W));

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($fell(busy_o) && !busy_o));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

bind dafir_filter dafir_filter_chk #(.SAMPLE_W(SAMPLE_W), .RW(RW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/dafir_filter_tb_top.sv
// Bench: directed corners plus seeded random samples, compared against a
// multiply-accumulate model over a history kept in the bench.
module dafir_filter_tb_top;

    localparam int TAPS = 9;
    localparam int SW   = 8;
    localparam int RW   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] din = '0;
    logic          bank = 1'b0;
    logic          busy;
    logic          done;
    logic [RW-1:0] result;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    int hist [TAPS];

    always #5 clk = ~clk;

    dafir_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .sample_i   (din),
        .bank_sel_i (bank),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    function automatic int ref_coef(input bit hp, input int i);
        int lp [TAPS] = '{2, 6, 15, 25, 30, 25, 15, 6, 2};
        int h  [TAPS] = '{-2, -6, -15, -25, 100, -25, -15, -6, -2};
        return hp ? h[i] : lp[i];
    endfunction

    function automatic int ref_mac(input bit hp);
        int s = 0;
        for (int i = 0; i < TAPS; i++) s += ref_coef(hp, i) * hist[i];
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One computation; meddle drives a stray start and a flipped bank while busy.
    task automatic run_one(input int x, input bit hp, input bit meddle, input string req);
        int exp_v;
        bit busy_ok;
        for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        exp_v = ref_mac(hp);
        @(negedge clk);
        start = 1'b1; din = SW'(x); bank = hp;
        @(posedge clk);
        busy_ok = 1'b1;
        for (int j = 0; j < SW; j++) begin
            @(negedge clk);
            if (!busy || done) busy_ok = 1'b0;
            start = meddle && (j < SW - 1);
            din   = SW'(~x);
            bank  = meddle ? ~hp : hp;
            @(posedge clk);
        end
        @(negedge clk);
        start = 1'b0;
        // R5: busy for exactly SW cycles; R6: done right after
        chk(busy_ok && !busy, "R5 busy window", int'(busy), 0);
        chk(done, "R6 done pulse", int'(done), 1);
        chk($signed(result) == exp_v, req, $signed(result), exp_v);
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R6 done single cycle", int'(done), 0);
        chk($signed(result) == exp_v, "R7 result held", $signed(result), exp_v);
    endtask

    initial begin
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(!busy && !done, "R9 flags after reset", int'(busy) + int'(done), 0);
        chk(result == '0, "R9 result after reset", $signed(result), 0);
        // R9/R1: impulse into zero history shows tap 0 coefficient only
        run_one(1, 1'b0, 1'b0, "R9 R1 impulse bank0");
        // R2/R3: walk the impulse through all taps, low-pass bank
        for (int k = 0; k < TAPS - 1; k++) run_one(0, 1'b0, 1'b0, "R2 R3 impulse walk lp");
        run_one(1, 1'b1, 1'b0, "R2 impulse hp");
        for (int k = 0; k < TAPS - 1; k++) run_one(0, 1'b1, 1'b0, "R2 impulse walk hp");
        // R10: most negative value fills history in both banks
        for (int k = 0; k < TAPS; k++) run_one(-128, 1'b0, 1'b0, "R10 min lp");
        run_one(-128, 1'b1, 1'b0, "R10 min hp");
        for (int k = 0; k < TAPS; k++) run_one(127, 1'b1, 1'b0, "R1 max hp");
        for (int k = 0; k < TAPS; k++) run_one((k % 2) ? 127 : -128, k % 3 == 0, 1'b0, "R1 alternating");
        // R4/R8: stray start and bank flips during busy are ignored
        for (int k = 0; k < 6; k++) run_one(k * 37 - 90, k[0], 1'b1, "R4 R8 ignored during busy");
        // R1: seeded random
        void'($urandom(32'd20240607));
        for (int k = 0; k < 300; k++) begin
            int r;
            r = int'($urandom() % 256) - 128;
            run_one(r, 1'($urandom() % 2), ($urandom() % 5) == 0, "R1 random");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule